// File: doc/BRIEF.md
# Float Exponent-Mantissa Decomposition Unit

This unit splits a single-precision IEEE-754 value into the two parts that range reduction needs before reciprocal, square-root, reciprocal-square-root or logarithm evaluation. One part is a rescaled mantissa, returned as a float. The other is a derived exponent, returned as a 32-bit two's-complement integer. The unit has no clock or state: a 3-bit opcode picks the operation, and the outputs follow the inputs through combinational logic.

A normal input is read as m·2^e, where m lies in [1,2) and e is the biased exponent field minus 127. The two mantissa operations write a fixed exponent field in place of the input's. The reciprocal operation gives [0.5,1). The square-root operation gives [0.25,1) and uses the parity of e, so that the leftover exponent is even. The three exponent operations give the integer that the matching table stage and the final rescale need. Subnormal inputs are flushed to a zero of the same sign before any of this.

Top module: `fxd_unit`

## Requirements
- R1: The unbiased exponent e of a normal input is its 8-bit biased field (bits 30:23) minus 127. An input with a zero exponent field and a nonzero fraction (subnormal) is treated exactly like a zero of the same sign by every operation.
- R2: Opcode 0 (reciprocal mantissa), normal input: the float output keeps the input sign (bit 31) and fraction (bits 22:0), its exponent field is 126, and the integer output is 0.
- R3: Opcode 1 (square-root mantissa), normal input: sign and fraction are kept. The exponent field is 125 when e is even and 126 when e is odd. The integer output is 0.
- R4: Opcodes 0 and 1 with a zero or subnormal input return the input sign bit with all other bits zero.
- R5: Opcodes 0 and 1 with an exponent field of 255 (infinity or NaN) return the input bit pattern unchanged.
- R6: Opcode 2 (reciprocal exponent), normal input: the integer output is -e-1 and the float output is 0.
- R7: Opcode 3 (square-root exponent), normal input: the integer output is floor(e/2)+1, with floor rounding toward negative infinity. The float output is 0.
- R8: Opcode 4 (reciprocal-square-root exponent), normal input: the integer output is -floor(e/2)-1 and the float output is 0.
- R9: Opcodes 2, 3 and 4 with a zero, subnormal, infinite or NaN input return integer 0.
- R10: Opcodes 5, 6 and 7 drive both outputs to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation select (0..4 defined, 5..7 unused) |
| val_i | input | 32 | Single-precision input operand |
| flt_o | output | 32 | Rescaled mantissa result (mantissa opcodes), else 0 |
| int_o | output | 32 | Signed derived exponent (exponent opcodes), else 0 |

## Verification
The hardest inputs to reach from the ports are the edges of the exponent range. These are the smallest and largest normal exponents, where -e-1 and the halving reach their extremes, and the negative odd exponents, where floor and truncation disagree. A uniform random operand almost never lands on a zero exponent field with a nonzero fraction, or on the all-ones field. The stimulus therefore takes the exponent field from a weighted choice among 0, 1, 254, 255 and a random value. The fraction and sign stay random. A directed list also covers the signed zeros, subnormals of both signs, both infinities and a NaN under every opcode.

// File: rtl/fxd_pkg.sv
package fxd_pkg;
  localparam int FLT_W  = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int BIAS   = 127;
  localparam int UE_W   = EXP_W + 2;   // unbiased exponent width, signed
  localparam int RES_W  = UE_W + 1;    // exponent-formula width, signed

  typedef enum logic [2:0] {
    OP_MANT_RCP  = 3'd0,
    OP_MANT_SQRT = 3'd1,
    OP_EXP_RCP   = 3'd2,
    OP_EXP_SQRT  = 3'd3,
    OP_EXP_RSQ   = 3'd4
  } fxd_op_e;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_SPEC = 2'd2
  } fxd_cls_e;

  // Biased field to signed unbiased exponent.
  function automatic logic signed [UE_W-1:0] unbias(input logic [EXP_W-1:0] f);
    return $signed({2'b00, f}) - $signed(UE_W'(BIAS));
  endfunction

  // Exponent formula for one of the three exponent operations.
  // k = 0: -e-1 ; k = 1: floor(e/2)+1 ; k = 2: -floor(e/2)-1
  function automatic logic signed [RES_W-1:0] exp_formula(input int k,
                                                          input logic signed [UE_W-1:0] e);
    logic signed [RES_W-1:0] ew;
    logic signed [RES_W-1:0] half;
    ew   = RES_W'(e);
    half = ew >>> 1;
    case (k)
      0:       return -ew - RES_W'(1);
      1:       return half + RES_W'(1);
      default: return -half - RES_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/fxd_classify.sv
module fxd_classify
  import fxd_pkg::*;
(
  input  logic [EXP_W-1:0]       ex_i,
  output fxd_cls_e               cls_o,
  output logic signed [UE_W-1:0] e_o
);
  always_comb begin
    if (ex_i == '0)      cls_o = CLS_ZERO;
    else if (ex_i == '1) cls_o = CLS_SPEC;
    else                 cls_o = CLS_NORM;
  end

  assign e_o = unbias(ex_i);
endmodule

// File: rtl/fxd_mant_scale.sv
module fxd_mant_scale
  import fxd_pkg::*;
(
  input  logic [FLT_W-1:0] val_i,
  input  fxd_cls_e         cls_i,
  input  logic             e_odd_i,
  input  logic             sqrt_sel_i,
  output logic [FLT_W-1:0] res_o
);
  localparam logic [EXP_W-1:0] FIELD_HALF    = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] FIELD_QUARTER = EXP_W'(BIAS - 2);

  logic             sgn;
  logic [FRAC_W-1:0] frac;
  logic [EXP_W-1:0]  new_field;

  assign sgn  = val_i[FLT_W-1];
  assign frac = val_i[FRAC_W-1:0];

  // Square-root mode leaves an even residual exponent: quarter scale for even e.
  assign new_field = (sqrt_sel_i && !e_odd_i) ? FIELD_QUARTER : FIELD_HALF;

  always_comb begin
    unique case (cls_i)
      CLS_NORM: res_o = {sgn, new_field, frac};
      CLS_SPEC: res_o = val_i;
      default:  res_o = {sgn, {(FLT_W-1){1'b0}}};
    endcase
  end
endmodule

// File: rtl/fxd_exp_derive.sv
module fxd_exp_derive
  import fxd_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int NUM_MODES = 3
)(
  input  logic signed [UE_W-1:0] e_i,
  input  fxd_cls_e               cls_i,
  input  logic [1:0]             mode_i,
  output logic [INT_W-1:0]       res_o
);
  logic signed [RES_W-1:0] cand [NUM_MODES];

  for (genvar k = 0; k < NUM_MODES; k++) begin : g_mode
    assign cand[k] = exp_formula(k, e_i);
  end

  logic signed [RES_W-1:0] picked;
  always_comb begin
    picked = '0;
    for (int k = 0; k < NUM_MODES; k++) begin
      if (int'(mode_i) == k) picked = cand[k];
    end
  end

  assign res_o = (cls_i == CLS_NORM) ? {{(INT_W-RES_W){picked[RES_W-1]}}, picked} : '0;
endmodule

// File: rtl/fxd_unit.sv
module fxd_unit
  import fxd_pkg::*;
#(
  parameter int INT_W = 32
)(
  input  logic [2:0]       op_i,
  input  logic [31:0]      val_i,
  output logic [31:0]      flt_o,
  output logic [INT_W-1:0] int_o
);
  // Named internal events, brought out for the checker.
  fxd_cls_e               cls_w;
  logic signed [UE_W-1:0] e_unb_w;
  logic                   e_odd_w;
  logic                   is_mant_w;
  logic                   is_exp_w;
  logic [1:0]             exp_mode_w;
  logic [FLT_W-1:0]       mant_res_w;
  logic [INT_W-1:0]       exp_res_w;

  fxd_classify u_cls (
    .ex_i  (val_i[FLT_W-2 -: EXP_W]),
    .cls_o (cls_w),
    .e_o   (e_unb_w)
  );

  assign e_odd_w = e_unb_w[0];

  always_comb begin
    is_mant_w  = 1'b0;
    is_exp_w   = 1'b0;
    exp_mode_w = 2'd0;
    case (op_i)
      OP_MANT_RCP, OP_MANT_SQRT: is_mant_w = 1'b1;
      OP_EXP_RCP:  begin is_exp_w = 1'b1; exp_mode_w = 2'd0; end
      OP_EXP_SQRT: begin is_exp_w = 1'b1; exp_mode_w = 2'd1; end
      OP_EXP_RSQ:  begin is_exp_w = 1'b1; exp_mode_w = 2'd2; end
      default: ;
    endcase
  end

  fxd_mant_scale u_mant (
    .val_i      (val_i),
    .cls_i      (cls_w),
    .e_odd_i    (e_odd_w),
    .sqrt_sel_i (op_i == OP_MANT_SQRT),
    .res_o      (mant_res_w)
  );

  fxd_exp_derive #(.INT_W(INT_W)) u_exp (
    .e_i    (e_unb_w),
    .cls_i  (cls_w),
    .mode_i (exp_mode_w),
    .res_o  (exp_res_w)
  );

  assign flt_o = is_mant_w ? mant_res_w : '0;
  assign int_o = is_exp_w  ? exp_res_w  : '0;
endmodule

// File: rtl/fxd_unit_chk.sv
module fxd_unit_chk
  import fxd_pkg::*;
#(
  parameter int INT_W = 32
)(
  input logic [2:0]       op_i,
  input logic [31:0]      val_i,
  input logic [31:0]      flt_o,
  input logic [INT_W-1:0] int_o,
  input fxd_cls_e         cls_w,
  input logic             e_odd_w
);
  logic [INT_W-1:0] rcp_exp_ref;
  assign rcp_exp_ref = INT_W'(126) - {{(INT_W-8){1'b0}}, val_i[30:23]};

  always_comb begin
    AST_UNUSED_OPS_ZERO: assert (!(op_i > 3'd4) || (flt_o == '0 && int_o == '0)) else $error("unused opcode output nonzero"); // R10
    AST_RCP_MANT_FIELD: assert (!(op_i == 3'd0 && cls_w == CLS_NORM) || (flt_o[30:23] == 8'd126 && flt_o[31] == val_i[31] && flt_o[22:0] == val_i[22:0])) else $error("reciprocal mantissa wrong"); // R2
    AST_SQRT_MANT_FIELD: assert (!(op_i == 3'd1 && cls_w == CLS_NORM) || (flt_o[30:23] == (e_odd_w ? 8'd126 : 8'd125) && flt_o[22:0] == val_i[22:0])) else $error("sqrt mantissa field wrong"); // R3
    AST_ZERO_MANT_SIGNED: assert (!(op_i < 3'd2 && val_i[30:23] == 8'd0) || flt_o == {val_i[31], 31'd0}) else $error("zero/subnormal not flushed"); // R4
    AST_SPECIAL_PASS: assert (!(op_i < 3'd2 && val_i[30:23] == 8'hFF) || flt_o == val_i) else $error("inf/nan not passed"); // R5
    AST_RCP_EXP_VALUE: assert (!(op_i == 3'd2 && cls_w == CLS_NORM) || int_o == rcp_exp_ref) else $error("reciprocal exponent wrong"); // R6
    AST_EXP_NONNORMAL_ZERO: assert (!(op_i >= 3'd2 && op_i <= 3'd4 && cls_w != CLS_NORM) || int_o == '0) else $error("nonnormal exponent nonzero"); // R9
    AST_MANT_INT_QUIET: assert (!(op_i < 3'd2) || int_o == '0) else $error("mantissa op drove integer"); // R2
    AST_EXP_FLT_QUIET: assert (!(op_i >= 3'd2 && op_i <= 3'd4) || flt_o == '0) else $error("exponent op drove float"); // R6
  end
endmodule

bind fxd_unit fxd_unit_chk #(.INT_W(INT_W)) chk_i (
  .op_i    (op_i),
  .val_i   (val_i),
  .flt_o   (flt_o),
  .int_o   (int_o),
  .cls_w   (cls_w),
  .e_odd_w (e_odd_w)
);

// File: tb/fxd_unit_tb.sv
module fxd_unit_tb_top;
  logic        clk = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [31:0] val_i = 32'd0;
  logic [31:0] flt_o;
  logic [31:0] int_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  fxd_unit dut_i (.op_i(op_i), .val_i(val_i), .flt_o(flt_o), .int_o(int_o));

  function automatic int fhalf(input int e);
    if (e >= 0) return e / 2;
    return -((1 - e) / 2);
  endfunction

  task automatic model(input logic [2:0] op, input logic [31:0] v,
                       output logic [31:0] ef, output logic [31:0] ei,
                       output string tag);
    int fld, e, r;
    bit sub, zer, spc;
    fld = int'(v[30:23]);
    e   = fld - 127;
    zer = (fld == 0);
    sub = zer && (v[22:0] != 0);
    spc = (fld == 255);
    ef = 32'd0; ei = 32'd0; r = 0;
    case (op)
      3'd0, 3'd1: begin
        if (zer) begin ef = {v[31], 31'd0}; tag = sub ? "R1" : "R4"; end
        else if (spc) begin ef = v; tag = "R5"; end
        else begin
          if (op == 3'd0) begin ef = {v[31], 8'd126, v[22:0]}; tag = "R2"; end
          else begin
            ef = {v[31], ((e % 2 == 0) ? 8'd125 : 8'd126), v[22:0]};
            tag = "R3";
          end
        end
      end
      3'd2, 3'd3, 3'd4: begin
        if (zer || spc) begin r = 0; tag = sub ? "R1" : "R9"; end
        else if (op == 3'd2) begin r = -e - 1; tag = "R6"; end
        else if (op == 3'd3) begin r = fhalf(e) + 1; tag = "R7"; end
        else begin r = -fhalf(e) - 1; tag = "R8"; end
        ei = 32'(r);
      end
      default: tag = "R10";
    endcase
  endtask

  task automatic apply(input logic [2:0] op, input logic [31:0] v);
    logic [31:0] ef, ei;
    string tag;
    @(posedge clk);
    #1;
    op_i  = op;
    val_i = v;
    model(op, v, ef, ei, tag);
    @(negedge clk);
    n_vec++;
    if (flt_o !== ef || int_o !== ei) begin
      n_bad++;
      $display("FAIL %s op=%0d in=%h flt=%h exp %h int=%h exp %h",
               tag, op, v, flt_o, ef, int_o, ei);
    end
  endtask

  logic [31:0] dir [14] = '{32'h3F800000, 32'h40000000, 32'h3F000000, 32'h40400000,
                            32'hC0800000, 32'h7F7FFFFF, 32'h00800000, 32'h00000001,
                            32'h80400000, 32'h00000000, 32'h80000000, 32'h7F800000,
                            32'hFF800000, 32'h7FC00001};

  initial begin
    logic [31:0] st;
    logic [7:0]  fld;
    // Reset state: opcode 0 on +0 yields all zeros (R4)
    @(negedge clk);
    n_vec++;
    if (flt_o !== 32'd0 || int_o !== 32'd0) begin
      n_bad++;
      $display("FAIL R4 initial flt=%h int=%h exp 0 0", flt_o, int_o);
    end
    for (int i = 0; i < 14; i++)
      for (int o = 0; o < 8; o++) apply(3'(o), dir[i]);
    // Negative odd exponents where floor differs from truncation (R7, R8)
    apply(3'd3, 32'h3E800000);  // e=-2
    apply(3'd3, 32'h3E000000);  // e=-3
    apply(3'd4, 32'h3E000000);
    apply(3'd2, 32'h00FFFFFF);  // e=-126 -> 125 (R6)
    st = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      st ^= st << 13; st ^= st >> 17; st ^= st << 5;
      case (st[2:0])
        3'd0: fld = 8'd0;
        3'd1: fld = 8'd255;
        3'd2: fld = 8'd1;
        3'd3: fld = 8'd254;
        default: fld = st[30:23];
      endcase
      apply(st[10:8] % 3'd7 == 3'd6 ? 3'd5 + 3'(st[11]) : st[10:8],
            {st[31], fld, st[22:0] ^ {st[7:0], st[31:17]}});
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule